// File: doc/BRIEF.md
# Strobe-Handshake Host Register Interface

This block attaches an asynchronous, byte-wide host bus to the four registers of a serial bus controller. The host bus has no clock. The host sets a 24-bit address and a read/write level, then lowers an address strobe and a data strobe. The block then either captures the write byte or presents the selected register's byte. It answers by pulling a transfer acknowledge low. The acknowledge stays low until the host has raised both strobes again.

All strobe and direction inputs are first brought into the system clock domain through two-flop synchronizers. A four-state controller then steps through idle, address-check, transfer and acknowledge. The upper address bits are compared with a base parameter, and the two lowest bits pick one of four registers. Register index 0 is the address register, 1 is control, 2 is status and 3 is data. The data bus is split into an input, an output and an output enable, so the pad level can form the tri-state pin.

Top module: `host_strobe_regif`

## Requirements
- R1: While reset is applied and right after it, the acknowledge is high, the output enable is low, the write pulse is low and all register selects are low.
- R2: If both strobes fall together between clock edges and the address hits, the acknowledge goes low at the fifth rising edge after the strobes fall.
- R3: If address bits [23:2] differ from bits [23:2] of the base parameter, no acknowledge and no write pulse follow, however long the strobes are held.
- R4: A hitting write produces exactly one single-cycle write pulse. During that pulse the write data output carries the byte that was on the data input, and the select output is one-hot at bit addr[1:0] (0 address, 1 control, 2 status, 3 data).
- R5: During a hitting read, while the acknowledge is low, the data output equals byte addr[1:0] of the read-data input, where byte i is bits [8i+7:8i].
- R6: The output enable is high only while the acknowledge is low in a read cycle. It stays low for writes and while idle.
- R7: The acknowledge stays low while either strobe is still low. It returns high by the third rising edge after the last strobe rises.
- R8: With only the address strobe low, the block waits in the address-check state without acknowledging. A data strobe that arrives later completes the transfer.
- R9: If the address strobe is raised before the data strobe arrives, the cycle is dropped: no acknowledge and no write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr_i | input | 24 | Host address |
| host_data_i | input | 8 | Host data bus, inbound level |
| host_data_o | output | 8 | Host data bus, outbound value |
| host_data_oe_o | output | 1 | Drive enable for the data bus pads |
| host_rw_i | input | 1 | 1 = read, 0 = write |
| host_as_n_i | input | 1 | Address strobe, active low |
| host_ds_n_i | input | 1 | Data strobe, active low |
| host_dtack_n_o | output | 1 | Transfer acknowledge, active low |
| reg_sel_o | output | 4 | One-hot register select during acknowledge |
| reg_wr_o | output | 1 | Single-cycle write pulse |
| reg_wdata_o | output | 8 | Captured write byte |
| reg_rdata_i | input | 32 | Read bytes of the four registers, byte i at [8i+7:8i] |

## Verification
The hardest behaviour to reach from the ports is the release phase. The acknowledge must hold while only one strobe has gone back high, and a cycle must be dropped when the address strobe goes away before the data strobe comes. Both depend on where the strobe edges fall relative to the synchronizer delay. The stimulus releases the address strobe several cycles ahead of the data strobe and checks that the acknowledge is still low. Directed cases raise the address strobe while the controller waits for the data strobe. The random cycles vary the data-strobe delay and the hold time, so strobe edges land in different states of the controller.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_XFER = 2'd2,
    ST_ACK  = 2'd3
  } hsr_state_e;

  localparam int REG_ADR = 0;
  localparam int REG_CTL = 1;
  localparam int REG_STA = 2;
  localparam int REG_DAT = 3;
endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hsr_decode.sv
module hsr_decode #(
  parameter int          ADDR_W    = 24,
  parameter int          SEL_W     = 2,
  parameter logic [23:0] BASE_ADDR = 24'hC0_0100
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  idx_o
);
  localparam int CMP_W = ADDR_W - SEL_W;

  logic [ADDR_W-1:0] base_full;
  assign base_full = ADDR_W'(BASE_ADDR);

  assign hit_o = (addr_i[ADDR_W-1:SEL_W] == base_full[ADDR_W-1:SEL_W]);
  assign idx_o = addr_i[SEL_W-1:0];

  logic [CMP_W-1:0] unused_width_tag;
  assign unused_width_tag = '0;
endmodule

// File: rtl/hsr_fsm.sv
module hsr_fsm
  import hsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       as_s,
  input  logic       ds_s,
  input  logic       hit_i,
  output hsr_state_e state_o,
  output logic       dtack_n_o
);
  hsr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (as_s) state_d = ST_ADDR;
      ST_ADDR: begin
        if (!as_s || !hit_i) state_d = ST_IDLE;
        else if (ds_s)       state_d = ST_XFER;
      end
      ST_XFER: state_d = ST_ACK;
      ST_ACK:  if (!as_s && !ds_s) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign dtack_n_o = (state_q != ST_ACK);

  AST_NOMATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && as_s && !hit_i) |=> (state_q == ST_IDLE)); // R3
  AST_WAIT_DS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && !ds_s) |=> (state_q != ST_XFER)); // R8
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && (as_s || ds_s)) |=> (state_q == ST_ACK)); // R7
  AST_ABORT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && !as_s) |=> (state_q == ST_IDLE)); // R9
endmodule

// File: rtl/host_strobe_regif.sv
module host_strobe_regif
  import hsr_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          DATA_W    = 8,
  parameter int          SEL_W     = 2,
  parameter int          SYNC_LEN  = 2,
  parameter logic [23:0] BASE_ADDR = 24'hC0_0100,
  localparam int         NUM_REGS  = 1 << SEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          host_addr_i,
  input  logic [DATA_W-1:0]          host_data_i,
  output logic [DATA_W-1:0]          host_data_o,
  output logic                       host_data_oe_o,
  input  logic                       host_rw_i,
  input  logic                       host_as_n_i,
  input  logic                       host_ds_n_i,
  output logic                       host_dtack_n_o,
  output logic [NUM_REGS-1:0]        reg_sel_o,
  output logic                       reg_wr_o,
  output logic [DATA_W-1:0]          reg_wdata_o,
  input  logic [NUM_REGS*DATA_W-1:0] reg_rdata_i
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // strobe and direction synchronizers, active-high inside
  logic [2:0] ctl_raw, ctl_s;
  assign ctl_raw = {host_rw_i, ~host_ds_n_i, ~host_as_n_i};

  hsr_sync #(.WIDTH(3), .STAGES(SYNC_LEN)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  logic as_s, ds_s, rw_s;
  assign as_s = ctl_s[0];
  assign ds_s = ctl_s[1];
  assign rw_s = ctl_s[2];

  logic             hit;
  logic [SEL_W-1:0] idx;

  hsr_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i (host_addr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  hsr_state_e state;
  hsr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .as_s      (as_s),
    .ds_s      (ds_s),
    .hit_i     (hit),
    .state_o   (state),
    .dtack_n_o (host_dtack_n_o)
  );

  logic [NUM_REGS-1:0] sel_d;
  always_comb begin
    sel_d = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == SEL_W'(i)) sel_d[i] = 1'b1;
    end
  end

  logic                xfer_en;
  logic                rw_q, wr_q;
  logic [DATA_W-1:0]   rd_q, wdata_q;
  logic [NUM_REGS-1:0] sel_q;

  assign xfer_en = (state == ST_XFER);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_q <= 1'b0;
    end else begin
      wr_q <= xfer_en && !rw_s;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rw_q    <= 1'b0;
      rd_q    <= '0;
      wdata_q <= '0;
      sel_q   <= '0;
    end else if (xfer_en) begin
      rw_q    <= rw_s;
      rd_q    <= reg_rdata_i[idx*DATA_W +: DATA_W];
      wdata_q <= host_data_i;
      sel_q   <= sel_d;
    end
  end

  assign host_data_oe_o = (state == ST_ACK) && rw_q;
  assign host_data_o    = host_data_oe_o ? rd_q : '0;
  assign reg_sel_o      = (state == ST_ACK) ? sel_q : '0;
  assign reg_wr_o       = wr_q;
  assign reg_wdata_o    = wdata_q;

  AST_OE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_data_oe_o |-> !host_dtack_n_o); // R6
  AST_WR_NOT_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr_o |-> !host_data_oe_o); // R6
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr_o |=> !reg_wr_o); // R4
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(reg_sel_o)); // R4
  AST_WR_HAS_SEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr_o |-> ($countones(reg_sel_o) == 1)); // R4
endmodule

// File: tb/tb_host_strobe_regif.sv
module tb_host_strobe_regif;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] BASE = 24'hC0_0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        oe;
  logic        rw;
  logic        as_n, ds_n;
  logic        dtack_n;
  logic [3:0]  sel;
  logic        wr;
  logic [7:0]  wdata;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  int wr_count = 0;
  logic [3:0] last_sel;
  logic [7:0] last_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_strobe_regif #(.BASE_ADDR(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .host_addr_i(addr), .host_data_i(din),
    .host_data_o(dout), .host_data_oe_o(oe), .host_rw_i(rw),
    .host_as_n_i(as_n), .host_ds_n_i(ds_n), .host_dtack_n_o(dtack_n),
    .reg_sel_o(sel), .reg_wr_o(wr), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  always @(negedge clk) begin
    if (wr) begin
      wr_count++;
      last_sel   = sel;
      last_wdata = wdata;
    end
  end

  function automatic bit exp_hit(input logic [23:0] a);
    return a[23:2] == BASE[23:2];
  endfunction

  function automatic logic [3:0] exp_sel(input logic [23:0] a);
    return 4'b0001 << a[1:0];
  endfunction

  function automatic logic [7:0] exp_byte(input logic [31:0] v, input logic [1:0] i);
    return v[i*8 +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one host cycle; returns cycles until acknowledge (0 if none)
  task automatic host_cycle(input logic [23:0] a, input logic r, input logic [7:0] wd,
                            input int ds_delay, input int hold, output int lat);
    int wc0;
    bit hit;
    hit = exp_hit(a);
    wc0 = wr_count;
    lat = 0;
    @(negedge clk);
    addr = a; rw = r; din = wd; rdata = {$urandom};
    as_n = 1'b0;
    if (ds_delay == 0) ds_n = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == ds_delay) ds_n = 1'b0;
      if (!dtack_n && lat == 0) lat = k;
      if (lat != 0) break;
    end
    if (!hit) begin
      chk(lat == 0, "R3 no ack on miss", lat, 0);
      chk(wr_count == wc0, "R3 no write on miss", wr_count - wc0, 0);
      as_n = 1'b1; ds_n = 1'b1;
      repeat (4) @(negedge clk);
      return;
    end
    chk(lat != 0, "R8 ack after strobes", lat, 1);
    chk(sel == exp_sel(a), "R4 select one-hot", sel, exp_sel(a));
    chk(oe == r, "R6 drive enable only on read", oe, r);
    if (r) chk(dout == exp_byte(rdata, a[1:0]), "R5 read byte", dout, exp_byte(rdata, a[1:0]));
    @(negedge clk);
    if (!r) begin
      chk(wr_count == wc0 + 1, "R4 one write pulse", wr_count - wc0, 1);
      chk(last_wdata == wd, "R4 write data", last_wdata, wd);
      chk(last_sel == exp_sel(a), "R4 select during write", last_sel, exp_sel(a));
    end else begin
      chk(wr_count == wc0, "R6 no write on read", wr_count - wc0, 0);
    end
    repeat (hold) @(negedge clk);
    as_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dtack_n == 1'b0, "R7 ack held while data strobe low", dtack_n, 0);
    ds_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dtack_n == 1'b1, "R7 ack released", dtack_n, 1);
    chk(oe == 1'b0, "R6 drive enable off after cycle", oe, 0);
    chk(wr_count == wc0 + (r ? 0 : 1), "R4 no extra pulse", wr_count - wc0, r ? 0 : 1);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lat;
    int wc0;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; addr = '0; din = '0; rw = 1'b0; as_n = 1'b1; ds_n = 1'b1; rdata = '0;
    repeat (3) @(negedge clk);
    chk(dtack_n == 1'b1, "R1 ack idle in reset", dtack_n, 1);
    chk(oe == 1'b0 && wr == 1'b0 && sel == 4'b0, "R1 outputs quiet in reset", {oe, wr, sel}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dtack_n == 1'b1 && oe == 1'b0 && sel == 4'b0, "R1 outputs quiet after reset", {dtack_n, oe, sel}, 6'h20);

    // R2 latency, both strobes together
    host_cycle(BASE | 24'h3, 1'b0, 8'hA5, 0, 0, lat);
    chk(lat == 5, "R2 ack latency", lat, 5);
    host_cycle(BASE | 24'h1, 1'b1, 8'h00, 0, 1, lat);
    chk(lat == 5, "R2 read latency", lat, 5);

    // R3 address just outside the range
    host_cycle(BASE + 24'h4, 1'b0, 8'h11, 0, 0, lat);
    host_cycle(BASE - 24'h1, 1'b1, 8'h11, 0, 0, lat);

    // R8 data strobe long after address strobe
    host_cycle(BASE | 24'h2, 1'b0, 8'h3C, 9, 0, lat);
    chk(lat == 13, "R8 waits for data strobe", lat, 13);

    // R9 address strobe dropped before data strobe
    wc0 = wr_count;
    @(negedge clk);
    addr = BASE; rw = 1'b0; din = 8'h77; as_n = 1'b0;
    repeat (5) @(negedge clk);
    as_n = 1'b1;
    @(negedge clk);
    ds_n = 1'b0;
    lat = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (!dtack_n) lat = 1;
    end
    ds_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(lat == 0, "R9 dropped cycle no ack", lat, 0);
    chk(wr_count == wc0, "R9 dropped cycle no write", wr_count - wc0, 0);
    host_cycle(BASE, 1'b1, 8'h00, 1, 0, lat);

    // random mix
    for (int n = 0; n < 80; n++) begin
      logic [23:0] a;
      a = ($urandom % 3 != 0) ? (BASE | 24'($urandom % 4)) : 24'($urandom);
      host_cycle(a, 1'($urandom), 8'($urandom), int'($urandom % 5), int'($urandom % 4), lat);
    end

    finish_run();
  end
endmodule